// File: doc/BRIEF.md
# Six-Step Brushless Motor Commutator with High-Side PWM Chopping

This block sequences the six conduction steps of a three-phase bridge for a sensorless brushless DC motor. A timer counts clock cycles and, when it reaches the programmed step period, clears itself and moves the bridge to the next step. Each step closes exactly one upper switch and one lower switch of the bridge. A free-running counter compared against a duty level chops the upper switches, while the lower switch of the active step stays closed.

The step timer can be kept from clearing on its compare. In that mode it still reports each compare match but does not advance the steps, so a neighbouring measurement sequencer can reuse the compare events as sampling instants. A force input turns the upper switch on at once for such samples. Two indicator bits from the speed controller are merged into the top of the bridge word. Period lookup, converter control and speed regulation live outside the block.

Top module: `bldc_commutator`

## Requirements
- R1: While reset is asserted and after its release until the first step change, `bridge_o` is 0x00 (with `status_i`=0), `phase_o` is 0, `drive_on_o` is 0 (with `force_on_i`=0), the step index is 6, the registered duty is 0 and the registered period is 0xFFFF.
- R2: Each step change moves the step index 6,5,4,3,2,1,6,...; index n is reported as `phase_o` = 7-n and drives word 0x21 (n=6), 0x24 (n=5), 0x06 (n=4), 0x12 (n=3), 0x18 (n=2), 0x09 (n=1). The first step change after reset therefore gives phase 2, word 0x24.
- R3: With `clr_en_i`=1, a step change happens in the cycle where the timer equals the registered period; the timer returns to 0 on the next edge, so steps repeat every period+1 cycles. `period_i` is registered one cycle before use.
- R4: With `clr_en_i`=0, a timer/period match raises `match_o` but no step change, `commute_o` stays 0 and the timer keeps counting without clearing.
- R5: The registered duty (one cycle after `duty_i`) plus an 8-bit counter that steps once per clock turns the drive on when the sum carries out of bit 7; over 256 cycles the drive is on for exactly duty cycles (duty up to 0xFD).
- R6: While the drive is off, the bridge word is ANDed with 0xD5: upper-switch bits 5 (C), 3 (B), 1 (A) are cleared and lower-switch bits 4 (C), 2 (B), 0 (A) are kept.
- R7: A registered duty above 0xFD (0xFE, 0xFF) keeps the drive on in every cycle and the word unmasked; 0xFD still chops.
- R8: `bridge_o[7:6]` equals `status_i` in the same cycle, whatever the drive state.
- R9: `force_on_i`=1 sets `drive_on_o` and the unmasked word in the same cycle, for any duty.
- R10: `commute_o` and `match_o` are single-cycle pulses for each compare with a nonzero period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | 16 | Step period compare value in clock cycles |
| duty_i | input | 8 | PWM duty level |
| clr_en_i | input | 1 | Timer clears and steps advance on compare when 1 |
| force_on_i | input | 1 | Forces the drive on immediately |
| status_i | input | 2 | Indicator bits merged into bridge bits 7:6 |
| bridge_o | output | 8 | Bridge switch word |
| phase_o | output | 3 | Current step 1..6, 0 before the first step |
| drive_on_o | output | 1 | PWM drive-on flag |
| commute_o | output | 1 | One-cycle step-change pulse |
| match_o | output | 1 | One-cycle timer compare pulse, in either timer mode |

## Verification
The step sequence is run with a short period at full duty so every word of the rotation, its phase number and the spacing between step pulses can be compared with fixed expected lists. The timer is then switched out of clear-on-match just after a step, which separates a compare event that only pulses from one that also advances the step. A table of duty levels, including zero, one, mid values and the 0xFD/0xFE boundary, with and without force and with each indicator pattern, counts drive-on cycles over a full counter lap; this distinguishes carry-based chopping from full-on bypass and forcing, and each off cycle checks that only upper-switch bits disappear.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;

   localparam int unsigned DRV_W     = 8;
   localparam int unsigned STAT_W    = 2;
   localparam int unsigned LEG_CNT   = 3;
   localparam int unsigned NUM_STEPS = 6;
   localparam int unsigned IDX_W     = 3;

   typedef logic [IDX_W-1:0] step_idx_t;
   typedef logic [DRV_W-1:0] drv_word_t;

   // Upper switches sit on the odd bits of each leg pair (A:1, B:3, C:5).
   function automatic drv_word_t upper_bits();
      drv_word_t m;
      m = '0;
      for (int l = 0; l < int'(LEG_CNT); l++) begin
         m[2*l+1] = 1'b1;
      end
      return m;
   endfunction

   localparam drv_word_t UPPER_MASK = upper_bits();
   localparam drv_word_t CHOP_MASK  = ~UPPER_MASK;

   // Step index to bridge word: one upper and one lower switch per step.
   function automatic drv_word_t step_word(input step_idx_t idx);
      drv_word_t w;
      unique case (idx)
         3'd6:    w = 8'h21;
         3'd5:    w = 8'h24;
         3'd4:    w = 8'h06;
         3'd3:    w = 8'h12;
         3'd2:    w = 8'h18;
         3'd1:    w = 8'h09;
         default: w = 8'h00;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/bldc_comm_timer.sv
module bldc_comm_timer #(
   parameter int unsigned TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] period_i,
   input  logic             clr_en_i,
   output logic             match_o,
   output logic             commute_o
);

   if (TMR_W < 2) begin : g_bad_width
      $error("bldc_comm_timer: TMR_W must be at least 2");
   end

   logic [TMR_W-1:0] period_q;
   logic [TMR_W-1:0] tmr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '1;
      end else begin
         period_q <= period_i;
      end
   end

   assign match_o   = (tmr_q == period_q);
   assign commute_o = match_o && clr_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q <= '0;
      end else if (commute_o) begin
         tmr_q <= '0;
      end else begin
         tmr_q <= tmr_q + 1'b1;
      end
   end

   assert_clear_on_step_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      commute_o |=> (tmr_q == '0));

   assert_no_clear_frozen_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (match_o && !clr_en_i) |=> (tmr_q == $past(tmr_q) + 1'b1));

   assert_single_pulse_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (commute_o && (period_i != '0)) |=> !commute_o);

endmodule

// File: rtl/bldc_phase_seq.sv
module bldc_phase_seq
   import bldc_comm_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 advance_i,
   output drv_word_t            word_o,
   output logic [IDX_W-1:0]     phase_o
);

   localparam step_idx_t TOP_IDX = step_idx_t'(NUM_STEPS);

   step_idx_t idx_q;
   step_idx_t idx_nxt;
   drv_word_t word_q;
   logic      started_q;

   assign idx_nxt = (idx_q == step_idx_t'(1)) ? TOP_IDX : idx_q - step_idx_t'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q     <= TOP_IDX;
         word_q    <= '0;
         started_q <= 1'b0;
      end else if (advance_i) begin
         idx_q     <= idx_nxt;
         word_q    <= step_word(idx_nxt);
         started_q <= 1'b1;
      end
   end

   assign word_o  = word_q;
   assign phase_o = started_q ? (step_idx_t'(NUM_STEPS + 1) - idx_q) : '0;

   assert_index_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q >= step_idx_t'(1)) && (idx_q <= TOP_IDX));

   assert_switch_pair_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      started_q |-> ($countones(word_q) == 2));

   assert_word_changes_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      advance_i |=> (word_q != $past(word_q)));

endmodule

// File: rtl/bldc_pwm_gate.sv
module bldc_pwm_gate
   import bldc_comm_pkg::*;
#(
   parameter int unsigned PWM_W         = 8,
   parameter int unsigned FULL_ON_LEVEL = 253
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PWM_W-1:0]  duty_i,
   input  logic              force_on_i,
   input  logic [STAT_W-1:0] status_i,
   input  drv_word_t         word_i,
   output drv_word_t         bridge_o,
   output logic              drive_on_o
);

   localparam int unsigned PWM_MAX = (1 << PWM_W) - 1;

   if (PWM_W < 2 || PWM_W > 16) begin : g_bad_width
      $error("bldc_pwm_gate: PWM_W out of range");
   end
   if (FULL_ON_LEVEL > PWM_MAX) begin : g_bad_level
      $error("bldc_pwm_gate: FULL_ON_LEVEL exceeds counter range");
   end

   logic [PWM_W-1:0] duty_q;
   logic [PWM_W-1:0] cnt_q;
   logic [PWM_W:0]   sum;
   logic             carry;
   logic             full_on;
   drv_word_t        gated;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= '0;
         cnt_q  <= '0;
      end else begin
         duty_q <= duty_i;
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign sum   = {1'b0, duty_q} + {1'b0, cnt_q};
   assign carry = sum[PWM_W];

   // The bypass vanishes when the level sits at the top of the counter range.
   if (FULL_ON_LEVEL == PWM_MAX) begin : g_no_full_on
      assign full_on = 1'b0;
   end else begin : g_full_on
      assign full_on = (duty_q > PWM_W'(FULL_ON_LEVEL));
   end

   assign drive_on_o = force_on_i || full_on || carry;
   assign gated      = drive_on_o ? word_i : (word_i & CHOP_MASK);
   assign bridge_o   = {status_i, gated[DRV_W-STAT_W-1:0]};

   assert_counter_step_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cnt_q == $past(cnt_q) + 1'b1));

   assert_off_drops_upper_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !drive_on_o |-> ((bridge_o & UPPER_MASK) == '0));

   assert_full_on_unmasked_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      full_on |-> (bridge_o[DRV_W-STAT_W-1:0] == word_i[DRV_W-STAT_W-1:0]));

   assert_force_on_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      force_on_i |-> drive_on_o);

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_comm_pkg::*;
#(
   parameter int unsigned TMR_W         = 16,
   parameter int unsigned PWM_W         = 8,
   parameter int unsigned FULL_ON_LEVEL = 253
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TMR_W-1:0]  period_i,
   input  logic [PWM_W-1:0]  duty_i,
   input  logic              clr_en_i,
   input  logic              force_on_i,
   input  logic [STAT_W-1:0] status_i,
   output logic [DRV_W-1:0]  bridge_o,
   output logic [IDX_W-1:0]  phase_o,
   output logic              drive_on_o,
   output logic              commute_o,
   output logic              match_o
);

   drv_word_t step_word_w;
   logic      step_pulse;

   bldc_comm_timer #(
      .TMR_W     (TMR_W)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .period_i  (period_i),
      .clr_en_i  (clr_en_i),
      .match_o   (match_o),
      .commute_o (step_pulse)
   );

   bldc_phase_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (step_pulse),
      .word_o    (step_word_w),
      .phase_o   (phase_o)
   );

   bldc_pwm_gate #(
      .PWM_W         (PWM_W),
      .FULL_ON_LEVEL (FULL_ON_LEVEL)
   ) u_pwm (
      .clk        (clk),
      .rst_n      (rst_n),
      .duty_i     (duty_i),
      .force_on_i (force_on_i),
      .status_i   (status_i),
      .word_i     (step_word_w),
      .bridge_o   (bridge_o),
      .drive_on_o (drive_on_o)
   );

   assign commute_o = step_pulse;

   assert_step_needs_enable_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      !clr_en_i |=> $stable(phase_o));

endmodule

// File: tb/bldc_commutator_tb_top.sv
module bldc_commutator_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYCLES = 150000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] period_i;
   logic [7:0]  duty_i;
   logic        clr_en_i;
   logic        force_on_i;
   logic [1:0]  status_i;
   logic [7:0]  bridge_o;
   logic [2:0]  phase_o;
   logic        drive_on_o;
   logic        commute_o;
   logic        match_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bldc_commutator dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_i   (period_i),
      .duty_i     (duty_i),
      .clr_en_i   (clr_en_i),
      .force_on_i (force_on_i),
      .status_i   (status_i),
      .bridge_o   (bridge_o),
      .phase_o    (phase_o),
      .drive_on_o (drive_on_o),
      .commute_o  (commute_o),
      .match_o    (match_o)
   );

   // duty, force, status, expected on-cycles in one counter lap
   localparam logic [19:0] PWM_VEC [0:9] = '{
      {8'h00, 1'b0, 2'b00, 9'd0},
      {8'h01, 1'b0, 2'b01, 9'd1},
      {8'h40, 1'b0, 2'b10, 9'd64},
      {8'h80, 1'b0, 2'b11, 9'd128},
      {8'hC7, 1'b0, 2'b00, 9'd199},
      {8'hFD, 1'b0, 2'b01, 9'd253},
      {8'hFE, 1'b0, 2'b10, 9'd256},
      {8'hFF, 1'b0, 2'b00, 9'd256},
      {8'h00, 1'b1, 2'b11, 9'd256},
      {8'h33, 1'b1, 2'b00, 9'd256}
   };

   localparam logic [7:0] SEQ_WORD [0:6] = '{8'h24, 8'h06, 8'h12, 8'h18, 8'h09, 8'h21, 8'h24};
   localparam logic [2:0] SEQ_PH   [0:6] = '{3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd1, 3'd2};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_step(output int n, input bit want_match);
      n = 0;
      do begin
         tick();
         n++;
      end while (!(want_match ? match_o : commute_o) && n < 200);
   endtask

   initial begin
      repeat (WDOG_CYCLES) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int n;
      int on_cnt;
      int stat_bad;
      int mask_bad;
      logic [2:0] held_ph;
      rst_n      = 1'b0;
      period_i   = 16'd0;
      duty_i     = 8'd0;
      clr_en_i   = 1'b0;
      force_on_i = 1'b0;
      status_i   = 2'b00;

      // R1: reset state
      repeat (3) tick();
      check("R1 bridge in reset", bridge_o, 8'h00);
      check("R1 phase in reset", phase_o, 3'd0);
      check("R1 drive_on in reset", drive_on_o, 1'b0);
      check("R1 no match in reset", match_o, 1'b0);
      rst_n = 1'b1;
      tick();
      check("R1 bridge after release", bridge_o, 8'h00);
      check("R1 phase after release", phase_o, 3'd0);
      check("R1 drive_on after release", drive_on_o, 1'b0);
      check("R1 no match with reset period", match_o, 1'b0);

      // R2/R3/R10: step rotation at full duty, period 4
      period_i = 16'd4;
      duty_i   = 8'hFF;
      clr_en_i = 1'b1;
      for (int k = 0; k < 7; k++) begin
         wait_step(n, 1'b0);
         check("R3 step pulse seen", commute_o, 1'b1);
         if (k > 0) check("R3 step spacing period+1", n + 1, 5);
         tick();
         check("R10 step pulse one cycle", commute_o, 1'b0);
         check("R2 step word", bridge_o, SEQ_WORD[k]);
         check("R2 phase number", phase_o, SEQ_PH[k]);
      end

      // R4: leave clear-on-match right after a step (timer is 0 now)
      period_i = 16'd20;
      clr_en_i = 1'b0;
      wait_step(n, 1'b1);
      check("R4 match seen without clear", match_o, 1'b1);
      check("R4 match after period cycles", n, 20);
      check("R4 no step pulse on match", commute_o, 1'b0);
      tick();
      check("R10 match pulse one cycle", match_o, 1'b0);
      held_ph = phase_o;
      check("R4 phase held", held_ph, 3'd2);
      n = 0;
      for (int c = 0; c < 100; c++) begin
         tick();
         if (match_o || phase_o != held_ph) n++;
      end
      check("R4 timer not cleared, no further match or step", n, 0);

      // R5..R9: duty table walked with phase 2 (word 0x24) held
      for (int r = 0; r < 10; r++) begin
         duty_i     = PWM_VEC[r][19:12];
         force_on_i = PWM_VEC[r][11];
         status_i   = PWM_VEC[r][10:9];
         tick();
         tick();
         on_cnt = 0; stat_bad = 0; mask_bad = 0;
         for (int c = 0; c < 256; c++) begin
            if (drive_on_o) begin
               on_cnt++;
               if (bridge_o[5:0] != 6'h24) mask_bad++;
            end else begin
               if (bridge_o[5:0] != 6'h04) mask_bad++;
            end
            if (bridge_o[7:6] != status_i) stat_bad++;
            tick();
         end
         if (PWM_VEC[r][11])
            check("R9 force keeps drive on", on_cnt, 32'(PWM_VEC[r][8:0]));
         else if (PWM_VEC[r][19:12] > 8'hFD)
            check("R7 full-on count", on_cnt, 32'(PWM_VEC[r][8:0]));
         else
            check("R5 on-cycles equal duty", on_cnt, 32'(PWM_VEC[r][8:0]));
         check("R6 off cycles drop only upper bits", mask_bad, 0);
         check("R8 status in bits 7:6", stat_bad, 0);
      end

      // R9: force takes effect in the same cycle
      duty_i     = 8'h00;
      force_on_i = 1'b0;
      status_i   = 2'b00;
      tick();
      tick();
      check("R5 duty zero drive off", drive_on_o, 1'b0);
      check("R6 masked word", bridge_o, 8'h04);
      force_on_i = 1'b1;
      #1;
      check("R9 force immediate drive_on", drive_on_o, 1'b1);
      check("R9 force immediate word", bridge_o, 8'h24);
      force_on_i = 1'b0;

      // R1: reset again mid-run
      duty_i = 8'hFF;
      tick();
      tick();
      rst_n = 1'b0;
      #1;
      check("R1 bridge after re-reset", bridge_o, 8'h00);
      check("R1 phase after re-reset", phase_o, 3'd0);
      check("R1 drive_on after re-reset", drive_on_o, 1'b0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule